// File: doc/BRIEF.md
# Posted-CAS Read/Write Latency Scheduler

This block sits on the device side of a double-data-rate memory command interface. On every rising clock edge it samples the command pins. It recognises column read and column write commands and ignores every other pattern. An accepted command is parked for a programmable additive latency (AL). After that it is issued internally as a one-cycle pulse. The posted delay is what lets a controller send a column command directly after a row activate.

Once a command is issued, the block schedules the data window for its burst. A read window opens RL = AL + CL edges after the sampling edge, and a write window opens WL = RL - 1 edges after it. Each window lasts BL/2 cycles because two beats move per clock. During a window the block reports the index of the first beat of the current pair and the bank the burst belongs to. Several commands can be in flight at once. Bursts that are spaced BL/2 cycles apart chain with no idle cycle between them.

Timing is stated in edges. The rising edge that samples the command is edge 0. An output said to be valid "after edge n" holds during the clock cycle that follows edge n.

Top module: `posted_cas_sched`

## Requirements
- R1: A read is accepted when, at a rising edge, cs_n=0, ras_n=1, cas_n=0 and we_n=1.
- R2: A write is accepted when, at a rising edge, cs_n=0, ras_n=1, cas_n=0 and we_n=0.
- R3: Any other pin pattern has no effect on any output. This covers cs_n=1, ras_n=0 (activate or refresh) and cas_n=1 (no-operation).
- R4: An accepted command produces rd_issue or wr_issue, according to its type, for exactly one cycle after edge AL. issue_ba carries the command's bank in that cycle. AL is the value on al, from 0 to 4.
- R5: For a read, rd_win is high during the cycles after edges RL to RL+BL/2-1, where RL = AL + CL and CL is the value on cl, from 3 to 5.
- R6: For a write, wr_win is high during the cycles after edges WL to WL+BL/2-1, where WL = RL - 1.
- R7: During a window, beat shows 0, 2, 4, 6 in successive cycles, up to BL-2, and win_ba shows the command's bank. Outside a window, beat is 0.
- R8: bl8=0 selects BL=4, which gives a 2-cycle window. bl8=1 selects BL=8, which gives a 4-cycle window.
- R9: Commands of the same type spaced BL/2 cycles apart are all kept. Their windows follow one another with no gap, and beat restarts at 0 for each burst.
- R10: A synchronous active-low reset drops all pending commands. From the cycle after the reset edge, every output is 0 until a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address of the command |
| al | input | 3 | Additive latency, 0 to 4 |
| cl | input | 3 | CAS latency, 3 to 5 |
| bl8 | input | 1 | 0 selects burst length 4, 1 selects burst length 8 |
| rd_issue | output | 1 | One-cycle pulse when a read takes effect internally |
| wr_issue | output | 1 | One-cycle pulse when a write takes effect internally |
| issue_ba | output | 3 | Bank of the command being issued |
| rd_win | output | 1 | Read data is being driven in this cycle |
| wr_win | output | 1 | Write data is being captured in this cycle |
| beat | output | 3 | Index of the first beat of the pair in this cycle |
| win_ba | output | 3 | Bank of the burst whose window is open |

## Verification
The bench builds the block with its default parameters: AL up to 4, CL up to 5 and BL up to 8. With these defaults the issue delay line holds five slots and the data delay line holds four. The bench changes al, cl and bl8 between scenarios and keeps them fixed within each one. The settings reach both extremes of the latency range: the shortest write path (AL=0, CL=3, which places the write in slot 0) and the longest read path (AL=4, CL=5, RL=9). The bench also runs chained bursts at both burst lengths and a reset that arrives while a command is still parked.

// File: rtl/ps_pkg.sv
// Package: shared types for the posted-CAS scheduler.
// Assumes a fixed bank-address width across the block.
package ps_pkg;
    localparam int PS_BA_W = 3;

    // One pending column command
    typedef struct packed {
        logic               vld;
        logic               wr;
        logic [PS_BA_W-1:0] ba;
    } ps_ent_t;
endpackage

// File: rtl/ps_cmd_decode.sv
// Module: ps_cmd_decode
// Purely combinational decode of the sampled command pins into a
// column command entry. Only read and write columns are flagged valid;
// all other patterns produce an empty entry.
// Assumes the pins are stable around the rising edge that samples them.
module ps_cmd_decode
    import ps_pkg::*;
(
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [PS_BA_W-1:0] ba,
    output ps_ent_t            ent
);
    logic col_cmd;

    // Column command: selected, row strobe idle, column strobe active
    always_comb begin
        col_cmd = !cs_n && ras_n && !cas_n;
        ent.vld = col_cmd;
        ent.wr  = col_cmd && !we_n;
        ent.ba  = col_cmd ? ba : '0;
    end
endmodule

// File: rtl/ps_lat_line.sv
// Module: ps_lat_line
// A delay line of DEPTH slots that shifts toward slot 0 on every edge.
// A new entry is written into slot push_idx and therefore reaches the
// head push_idx edges later. Several entries can be in flight at once.
// Assumes the caller never places two entries in the same slot in the
// same cycle; the assertion below guards that.
module ps_lat_line
    import ps_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ps_ent_t          push_ent,
    input  logic [IDX_W-1:0] push_idx,
    output ps_ent_t          head
);
    ps_ent_t q       [DEPTH];
    ps_ent_t shifted [DEPTH];
    ps_ent_t nxt     [DEPTH];

    // Shift network: slot g takes slot g+1, the top slot empties
    for (genvar g = 0; g < DEPTH; g++) begin : g_shift
        if (g == DEPTH - 1) begin : g_top
            assign shifted[g] = '0;
        end else begin : g_mid
            assign shifted[g] = q[g+1];
        end
    end

    // Next state: the shifted line plus the new entry at its slot
    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = shifted[i];
        if (push_ent.vld) nxt[push_idx] = push_ent;
    end

    // Slot registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
        end
    end

    assign head = q[0];

    // The new entry must not land on one that is already in flight
    assert_slot_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_ent.vld |-> !shifted[push_idx].vld);

    // The requested slot must exist
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_ent.vld |-> ({1'b0, push_idx} < (IDX_W+1)'(DEPTH)));
endmodule

// File: rtl/ps_burst_gen.sv
// Module: ps_burst_gen
// Opens a data window one edge after a start entry is seen and holds it
// for BL/2 cycles. The beat index steps by two per cycle. A start that
// arrives in a window's last cycle chains straight into a new window.
// Assumes starts are spaced at least BL/2 cycles apart.
module ps_burst_gen
    import ps_pkg::*;
#(
    parameter  int BL_MAX = 8,
    localparam int BEAT_W = $clog2(BL_MAX),
    localparam int CYC_W  = (BL_MAX > 4) ? $clog2(BL_MAX/2) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ps_ent_t            start,
    input  logic               bl8,
    output logic               rd_win,
    output logic               wr_win,
    output logic [BEAT_W-1:0]  beat,
    output logic [PS_BA_W-1:0] win_ba
);
    logic             act;
    logic             typ_wr;
    logic [CYC_W-1:0] rem;

    // Window state: load on start, step the beat, close when done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            typ_wr <= 1'b0;
            beat   <= '0;
            rem    <= '0;
            win_ba <= '0;
        end else if (start.vld) begin
            act    <= 1'b1;
            typ_wr <= start.wr;
            beat   <= '0;
            rem    <= bl8 ? CYC_W'(BL_MAX/2 - 1) : CYC_W'(BL_MAX/4 - 1);
            win_ba <= start.ba;
        end else if (act && rem != '0) begin
            beat <= beat + BEAT_W'(2);
            rem  <= rem - CYC_W'(1);
        end else begin
            act    <= 1'b0;
            beat   <= '0;
            win_ba <= '0;
        end
    end

    // Window outputs split by type
    assign rd_win = act && !typ_wr;
    assign wr_win = act && typ_wr;

    // A start opens a window at beat 0 on the next cycle
    assert_beat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start.vld |=> (beat == '0 && (rd_win || wr_win)));

    // Inside a window the beat index advances by one pair per cycle
    assert_beat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act && rem != '0 && !start.vld) |=> (beat == $past(beat) + BEAT_W'(2)));

    // After the last pair the window closes unless a new burst chains in
    assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && rem == '0 && !start.vld) |=> (!rd_win && !wr_win && beat == '0));
endmodule

// File: rtl/posted_cas_sched.sv
// Module: posted_cas_sched (top)
// Decodes column commands and holds each one for AL edges in an issue
// line before pulsing it out. It then places the issued command in a
// data line, so the window opens after RL edges for a read and after
// RL-1 edges for a write.
// Assumes al, cl and bl8 stay stable while any command is pending, with
// al in 0..AL_MAX and cl in 3..CL_MAX.
module posted_cas_sched
    import ps_pkg::*;
#(
    parameter  int AL_MAX  = 4,
    parameter  int CL_MAX  = 5,
    parameter  int BL_MAX  = 8,
    localparam int AL_W    = $clog2(AL_MAX + 1),
    localparam int CL_W    = $clog2(CL_MAX + 1),
    localparam int BEAT_W  = $clog2(BL_MAX),
    localparam int IL_DEP  = AL_MAX + 1,
    localparam int IL_IW   = (IL_DEP > 1) ? $clog2(IL_DEP) : 1,
    // Read: issue register, data line and window register add up to CL
    localparam int RD_SKEW = 2,
    // Write: one edge less than read
    localparam int WR_SKEW = RD_SKEW + 1,
    localparam int DL_DEP  = CL_MAX - RD_SKEW + 1,
    localparam int DL_IW   = (DL_DEP > 1) ? $clog2(DL_DEP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [PS_BA_W-1:0] ba,
    input  logic [AL_W-1:0]    al,
    input  logic [CL_W-1:0]    cl,
    input  logic               bl8,
    output logic               rd_issue,
    output logic               wr_issue,
    output logic [PS_BA_W-1:0] issue_ba,
    output logic               rd_win,
    output logic               wr_win,
    output logic [BEAT_W-1:0]  beat,
    output logic [PS_BA_W-1:0] win_ba
);
    ps_ent_t          cmd_ent;
    ps_ent_t          issue_head;
    ps_ent_t          data_head;
    logic [IL_IW-1:0] il_idx;
    logic [CL_W-1:0]  skew;
    logic [DL_IW-1:0] dl_idx;

    ps_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .ent   (cmd_ent)
    );

    // Issue slot: the command reaches the head AL edges after sampling
    assign il_idx = IL_IW'(al);

    ps_lat_line #(.DEPTH(IL_DEP)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_ent (cmd_ent),
        .push_idx (il_idx),
        .head     (issue_head)
    );

    // Issue pulses and bank
    assign rd_issue = issue_head.vld && !issue_head.wr;
    assign wr_issue = issue_head.vld && issue_head.wr;
    assign issue_ba = issue_head.ba;

    // Data slot: the remaining CL (read) or CL-1 (write) edges
    always_comb begin
        skew   = issue_head.wr ? CL_W'(WR_SKEW) : CL_W'(RD_SKEW);
        dl_idx = DL_IW'(cl - skew);
    end

    ps_lat_line #(.DEPTH(DL_DEP)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_ent (issue_head),
        .push_idx (dl_idx),
        .head     (data_head)
    );

    ps_burst_gen #(.BL_MAX(BL_MAX)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (data_head),
        .bl8    (bl8),
        .rd_win (rd_win),
        .wr_win (wr_win),
        .beat   (beat),
        .win_ba (win_ba)
    );

    // Reset leaves no issue pulse and no window in the next cycle
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!rd_issue && !wr_issue && !rd_win && !wr_win));

    // Column commands are at least two cycles apart, so each issue is one pulse
    assert_issue_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue || wr_issue) |=> !(rd_issue || wr_issue));
endmodule

// File: tb/sim_posted_cas_sched.sv
module sim_posted_cas_sched;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, ras_n, cas_n, we_n;
    logic [2:0] ba, al, cl;
    logic       bl8;
    logic       rd_issue, wr_issue, rd_win, wr_win;
    logic [2:0] issue_ba, beat, win_ba;

    always #10 clk = ~clk;

    posted_cas_sched u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .al(al), .cl(cl), .bl8(bl8),
        .rd_issue(rd_issue), .wr_issue(wr_issue), .issue_ba(issue_ba),
        .rd_win(rd_win), .wr_win(wr_win), .beat(beat), .win_ba(win_ba)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Kinds: 0 read, 1 write, 2 activate, 3 deselected, 4 refresh, 5 nop
    int c_kind[8];
    int c_off[8];
    int c_ba[8];
    int n_cmd;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(int kind, int bav);
        ba = 3'(bav);
        case (kind)
            0: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            1: {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            2: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            3: {cs_n, ras_n, cas_n, we_n} = 4'b1100;
            4: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            5: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    endtask

    task automatic set_mode(int a, int c, int b8);
        al = 3'(a); cl = 3'(c); bl8 = b8[0];
    endtask

    // Runs the loaded command list; expected values come from AL/CL/BL rules
    task automatic run_seq(string tag);
        int last = 0;
        for (int j = 0; j < n_cmd; j++) if (c_off[j] > last) last = c_off[j];
        for (int k = 0; k <= last + 16; k++) begin
            int e_ri = 0, e_wi = 0, e_ib = 0, e_rw = 0, e_ww = 0, e_bt = 0, e_wb = 0;
            drive(9, 0);
            for (int j = 0; j < n_cmd; j++) if (c_off[j] == k) drive(c_kind[j], c_ba[j]);
            @(posedge clk);
            @(negedge clk);
            drive(9, 0);
            for (int j = 0; j < n_cmd; j++) begin
                if (c_kind[j] <= 1) begin
                    int d   = k - c_off[j];
                    int lat = int'(al) + int'(cl) - c_kind[j];
                    int n   = bl8 ? 4 : 2;
                    if (d == int'(al)) begin
                        if (c_kind[j] == 0) e_ri = 1; else e_wi = 1;
                        e_ib = c_ba[j];
                    end
                    if (d >= lat && d < lat + n) begin
                        if (c_kind[j] == 0) e_rw = 1; else e_ww = 1;
                        e_bt = 2 * (d - lat);
                        e_wb = c_ba[j];
                    end
                end
            end
            chk({tag, " R4 rd_issue"}, int'(rd_issue), e_ri);
            chk({tag, " R4 wr_issue"}, int'(wr_issue), e_wi);
            if (e_ri != 0 || e_wi != 0) chk({tag, " R4 issue_ba"}, int'(issue_ba), e_ib);
            chk({tag, " R5 rd_win"}, int'(rd_win), e_rw);
            chk({tag, " R6 wr_win"}, int'(wr_win), e_ww);
            chk({tag, " R7 beat"}, int'(beat), e_bt);
            if (e_rw != 0 || e_ww != 0) chk({tag, " R7 win_ba"}, int'(win_ba), e_wb);
        end
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        drive(9, 0);
        set_mode(0, 3, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset rd_issue", int'(rd_issue), 0);
        chk("R10 reset wr_issue", int'(wr_issue), 0);
        chk("R10 reset rd_win", int'(rd_win), 0);
        chk("R10 reset wr_win", int'(wr_win), 0);
        chk("R10 reset beat", int'(beat), 0);
        rst_n = 1'b1;
    endtask

    // R1 read and R2 write at AL=2 CL=3 BL4 (RL=5, WL=4)
    task automatic test_single_rw();
        set_mode(2, 3, 0);
        n_cmd = 1; c_kind[0] = 0; c_off[0] = 0; c_ba[0] = 5;
        run_seq("R1 read al2");
        n_cmd = 1; c_kind[0] = 1; c_off[0] = 0; c_ba[0] = 3;
        run_seq("R2 write al2");
    endtask

    // AL=0 gives RL=3 and WL=2, the shortest paths
    task automatic test_no_al();
        set_mode(0, 3, 0);
        n_cmd = 2;
        c_kind[0] = 0; c_off[0] = 0; c_ba[0] = 1;
        c_kind[1] = 1; c_off[1] = 8; c_ba[1] = 6;
        run_seq("R5 R6 al0");
    endtask

    // R8: BL8 at the longest latency, read then write
    task automatic test_bl8();
        set_mode(4, 5, 1);
        n_cmd = 2;
        c_kind[0] = 0; c_off[0] = 0; c_ba[0] = 7;
        c_kind[1] = 1; c_off[1] = 8; c_ba[1] = 2;
        run_seq("R8 bl8 al4 cl5");
    endtask

    // R3: non-column patterns ignored, read right after activate
    task automatic test_ignored();
        set_mode(1, 4, 0);
        n_cmd = 6;
        c_kind[0] = 2; c_off[0] = 0; c_ba[0] = 4;
        c_kind[1] = 0; c_off[1] = 1; c_ba[1] = 4;
        c_kind[2] = 3; c_off[2] = 3; c_ba[2] = 1;
        c_kind[3] = 4; c_off[3] = 4; c_ba[3] = 2;
        c_kind[4] = 5; c_off[4] = 5; c_ba[4] = 3;
        c_kind[5] = 2; c_off[5] = 7; c_ba[5] = 6;
        run_seq("R3 ignored");
    endtask

    // R9: chained bursts at BL4 and BL8
    task automatic test_chain();
        set_mode(1, 4, 0);
        n_cmd = 3;
        c_kind[0] = 0; c_off[0] = 0; c_ba[0] = 1;
        c_kind[1] = 0; c_off[1] = 2; c_ba[1] = 2;
        c_kind[2] = 0; c_off[2] = 4; c_ba[2] = 3;
        run_seq("R9 read chain bl4");
        set_mode(3, 3, 1);
        n_cmd = 3;
        c_kind[0] = 1; c_off[0] = 0; c_ba[0] = 5;
        c_kind[1] = 1; c_off[1] = 4; c_ba[1] = 6;
        c_kind[2] = 1; c_off[2] = 8; c_ba[2] = 7;
        run_seq("R9 write chain bl8");
    endtask

    // R10: reset while a read is still parked
    task automatic test_mid_reset();
        set_mode(4, 5, 0);
        drive(0, 2);
        @(posedge clk);
        @(negedge clk);
        drive(9, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            chk("R10 flush issue", int'(rd_issue | wr_issue), 0);
            chk("R10 flush window", int'(rd_win | wr_win), 0);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        test_reset_state();
        @(negedge clk);
        test_single_rw();
        test_no_al();
        test_bl8();
        test_ignored();
        test_chain();
        test_mid_reset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule